// File: doc/BRIEF.md
# DRAM Rank Command Timing Checker

This block watches the command stream that a memory controller sends to one DRAM rank. It keeps a table with one entry per bank. Each entry holds the bank's condition (idle, row open, or asleep), the row it has open, and the earliest cycle at which the bank may next take an activate, a read, a write, a precharge or a power-up. A free-running cycle counter supplies the current cycle. Each command is checked against the table. A legal command then updates its own bank's entry and, for most command types, the entries of every other bank as well. All timing values are module parameters.

When a command, a power-down request or a power-up request breaks a rule, the block sets a violation flag and latches an error code naming that first offending request. The flag and the code hold until reset. An illegal request leaves the table untouched. Legal requests that arrive later are still tracked, so the bank condition outputs stay accurate.

Two state machines set the block's behaviour. The rank power machine has the states RANK_RUN and RANK_DOWN. It moves from RANK_RUN to RANK_DOWN on a legal power-down (transition GO_SLEEP) and back on a legal power-up (transition WAKE). The violation machine has the states VIOL_CLEAN and VIOL_TRIPPED. It takes the single transition TRIP on the first illegal request and then stays in VIOL_TRIPPED. Each bank entry has the states BANK_IDLE, BANK_OPEN and BANK_SLEEP, with these transitions: OPEN_ROW (activate), CLOSE_ROW (precharge or an auto-precharge access), SLEEP (power-down) and WAKE (power-up).

Top module: `rank_cmd_guard`

## Requirements
- R1: After reset, viol_flag is 0, viol_code is 0, every bank_open bit is 0 and rank_asleep is 0.
- R2: A read (op 2, 3) or write (op 4, 5) is legal only if the bank has a row open, that row equals cmd_row, and the current cycle is at or past the bank's read bound (for reads) or write bound (for writes). An illegal read gives code 3 (plain read) or 4 (read with auto-precharge). An illegal write gives code 5 (plain write) or 6 (write with auto-precharge).
- R3: An activate (op 0) is legal only on an idle bank at or past its activate bound. Illegal gives code 1. A legal activate opens cmd_row and sets that bank's bounds: activate to now+T_RC, read and write to now+(T_RCD−T_AL), precharge to now+T_RAS.
- R4: A legal activate raises every other bank's activate bound to at least now+T_RRD.
- R5: A legal read raises its bank's precharge bound to at least now+T_RTP. It raises every bank's read bound to at least now+max(T_CCD, BL/2) and every bank's write bound to at least now+T_RTW.
- R6: A legal write raises its bank's precharge bound to at least now+T_WTP. It raises every bank's read bound to at least now+T_WTR and every bank's write bound to at least now+max(T_CCD, BL/2).
- R7: A legal read or write with auto-precharge makes the bank idle at once. It also applies the rank-wide read/write bounds of R5 or R6 and raises the bank's activate bound to at least now+T_RDA or now+T_WRA.
- R8: A precharge (op 1) needs an open row and the precharge bound to be reached. Illegal gives code 2. A legal precharge makes the bank idle and raises its activate bound to at least now+T_RP.
- R9: A refresh (op 6) needs every bank idle. Illegal gives code 7. A legal refresh sets every bank's activate bound to now+T_RFC.
- R10: Power-down (pd_req) needs every bank idle and the rank awake. Illegal gives code 8. A legal power-down sets rank_asleep, puts all banks asleep and sets the power-up bound to now+T_CKE. Power-up (pu_req) needs the rank asleep and that bound reached. Illegal gives code 9. A legal power-up clears rank_asleep, makes all banks idle and sets their activate bound to now+T_XP.
- R11: viol_flag stays set until reset. viol_code keeps the code of the first illegal request. An illegal request changes neither the table nor rank_asleep.
- R12: Opcode 7 is reserved. Presenting it with cmd_valid gives code 10.
- R13: cmd_valid takes priority over power requests, and pd_req takes priority over pu_req. A request with lower priority in the same cycle is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command opcode: 0 activate, 1 precharge, 2 read, 3 read+auto-precharge, 4 write, 5 write+auto-precharge, 6 refresh, 7 reserved |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Target row |
| pd_req | input | 1 | Power-down request |
| pu_req | input | 1 | Power-up request |
| viol_flag | output | 1 | Sticky violation flag |
| viol_code | output | 4 | Code of the first violation (0 when none) |
| bank_open | output | NUM_BANKS | Per-bank row-open indication |
| rank_asleep | output | 1 | Rank is powered down |

## Verification
The hardest case to reach is one where a bound was raised by a command to a different bank, or by an earlier command of another class, and then has to be distinguished from the bank's own bound. Examples are a read to bank 1 that is blocked only by the shared gap from a read to bank 0, and a precharge that is blocked by a read issued after a write rather than by the row-open time. The stimulus places each probe exactly one cycle before the bound it targets, after arranging for every other bound to have already passed. This requires that each such scenario start from a fresh reset, because the flag is sticky. Priority between simultaneous command and power requests is checked by pairing a request that would be legal with one that would be illegal.

// File: rtl/rank_guard_pkg.sv
package rank_guard_pkg;

    typedef enum logic [2:0] {
        OP_ACT = 3'd0,
        OP_PRE = 3'd1,
        OP_RD  = 3'd2,
        OP_RDA = 3'd3,
        OP_WR  = 3'd4,
        OP_WRA = 3'd5,
        OP_REF = 3'd6,
        OP_RSV = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        BANK_IDLE  = 2'd0,
        BANK_OPEN  = 2'd1,
        BANK_SLEEP = 2'd2
    } bank_st_e;

    typedef enum logic [3:0] {
        ERR_NONE = 4'd0,
        ERR_ACT  = 4'd1,
        ERR_PRE  = 4'd2,
        ERR_RD   = 4'd3,
        ERR_RDA  = 4'd4,
        ERR_WR   = 4'd5,
        ERR_WRA  = 4'd6,
        ERR_REF  = 4'd7,
        ERR_PDN  = 4'd8,
        ERR_PUP  = 4'd9,
        ERR_OP   = 4'd10
    } err_e;

    typedef enum logic {
        RANK_RUN  = 1'b0,
        RANK_DOWN = 1'b1
    } rank_st_e;

    typedef enum logic {
        VIOL_CLEAN   = 1'b0,
        VIOL_TRIPPED = 1'b1
    } viol_st_e;

endpackage

// File: rtl/rank_bank_timer.sv
module rank_bank_timer
    import rank_guard_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ROW_W  = 8,
    parameter int T_RC   = 10,
    parameter int T_CAS  = 3,
    parameter int T_RAS  = 7,
    parameter int T_RRD  = 2,
    parameter int T_RW   = 4,
    parameter int T_RTP  = 3,
    parameter int T_WTP  = 6,
    parameter int T_RTW  = 5,
    parameter int T_WTR  = 7,
    parameter int T_RDA  = 8,
    parameter int T_WRA  = 11,
    parameter int T_RP   = 2,
    parameter int T_RFC  = 12,
    parameter int T_CKE  = 3,
    parameter int T_XP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] now,
    input  logic             apply,
    input  op_e              op,
    input  logic             own,
    input  logic [ROW_W-1:0] row,
    input  logic             pd_go,
    input  logic             pu_go,
    output bank_st_e         st,
    output logic [ROW_W-1:0] open_row,
    output logic [CNT_W-1:0] nxt_act,
    output logic [CNT_W-1:0] nxt_rd,
    output logic [CNT_W-1:0] nxt_wr,
    output logic [CNT_W-1:0] nxt_pre,
    output logic [CNT_W-1:0] nxt_pu
);

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] cur,
                                              input logic [CNT_W-1:0] lim);
        return (lim > cur) ? lim : cur;
    endfunction

    bank_st_e         st_d;
    logic [ROW_W-1:0] row_d;
    logic [CNT_W-1:0] act_d, rd_d, wr_d, pre_d, pu_d;

    always_comb begin
        st_d  = st;
        row_d = open_row;
        act_d = nxt_act;
        rd_d  = nxt_rd;
        wr_d  = nxt_wr;
        pre_d = nxt_pre;
        pu_d  = nxt_pu;
        if (pd_go) begin
            st_d = BANK_SLEEP;
            pu_d = now + CNT_W'(T_CKE);
        end else if (pu_go) begin
            st_d  = BANK_IDLE;
            act_d = now + CNT_W'(T_XP);
        end else if (apply) begin
            unique case (op)
                OP_ACT: begin
                    if (own) begin
                        st_d  = BANK_OPEN;
                        row_d = row;
                        act_d = now + CNT_W'(T_RC);
                        rd_d  = now + CNT_W'(T_CAS);
                        wr_d  = now + CNT_W'(T_CAS);
                        pre_d = now + CNT_W'(T_RAS);
                    end else begin
                        act_d = bump(nxt_act, now + CNT_W'(T_RRD));
                    end
                end
                OP_PRE: begin
                    if (own) begin
                        st_d  = BANK_IDLE;
                        act_d = bump(nxt_act, now + CNT_W'(T_RP));
                    end
                end
                OP_RD, OP_RDA: begin
                    rd_d = bump(nxt_rd, now + CNT_W'(T_RW));
                    wr_d = bump(nxt_wr, now + CNT_W'(T_RTW));
                    if (own) begin
                        if (op == OP_RD) begin
                            pre_d = bump(nxt_pre, now + CNT_W'(T_RTP));
                        end else begin
                            st_d  = BANK_IDLE;
                            act_d = bump(nxt_act, now + CNT_W'(T_RDA));
                        end
                    end
                end
                OP_WR, OP_WRA: begin
                    rd_d = bump(nxt_rd, now + CNT_W'(T_WTR));
                    wr_d = bump(nxt_wr, now + CNT_W'(T_RW));
                    if (own) begin
                        if (op == OP_WR) begin
                            pre_d = bump(nxt_pre, now + CNT_W'(T_WTP));
                        end else begin
                            st_d  = BANK_IDLE;
                            act_d = bump(nxt_act, now + CNT_W'(T_WRA));
                        end
                    end
                end
                OP_REF: begin
                    act_d = now + CNT_W'(T_RFC);
                end
                OP_RSV: begin
                    st_d = st;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= BANK_IDLE;
            open_row <= '0;
            nxt_act  <= '0;
            nxt_rd   <= '0;
            nxt_wr   <= '0;
            nxt_pre  <= '0;
            nxt_pu   <= '0;
        end else begin
            st       <= st_d;
            open_row <= row_d;
            nxt_act  <= act_d;
            nxt_rd   <= rd_d;
            nxt_wr   <= wr_d;
            nxt_pre  <= pre_d;
            nxt_pu   <= pu_d;
        end
    end

    // R3
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && op == OP_ACT && own && !pd_go && !pu_go) |=> (st == BANK_OPEN && open_row == $past(row)));

    // R5
    rd_bound_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(apply && op == OP_ACT && own) |=> (nxt_rd >= $past(nxt_rd)));

    // R8
    pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && own && (op == OP_PRE || op == OP_RDA || op == OP_WRA) && !pd_go && !pu_go)
        |=> (st == BANK_IDLE));

endmodule

// File: rtl/rank_rule_check.sv
module rank_rule_check
    import rank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 8,
    parameter int CNT_W     = 32
) (
    input  logic                             cmd_valid,
    input  op_e                              op,
    input  logic [BANK_W-1:0]                bank,
    input  logic [ROW_W-1:0]                 row,
    input  logic                             pd_req,
    input  logic                             pu_req,
    input  rank_st_e                         rank_st,
    input  logic [CNT_W-1:0]                 now,
    input  logic [NUM_BANKS-1:0][1:0]        bst,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0]  orow,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]  b_act,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]  b_rd,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]  b_wr,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]  b_pre,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]  b_pu,
    output logic                             apply,
    output logic                             pd_go,
    output logic                             pu_go,
    output logic                             bad,
    output err_e                             bad_code
);

    logic all_idle, pu_time_ok, row_hit, ok;

    always_comb begin
        all_idle   = 1'b1;
        pu_time_ok = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bst[i] != BANK_IDLE) all_idle = 1'b0;
            if (now < b_pu[i])       pu_time_ok = 1'b0;
        end
    end

    assign row_hit = (bst[bank] == BANK_OPEN) && (orow[bank] == row);

    always_comb begin
        ok       = 1'b0;
        bad_code = ERR_NONE;
        unique case (op)
            OP_ACT: begin ok = (bst[bank] == BANK_IDLE) && (now >= b_act[bank]); bad_code = ERR_ACT; end
            OP_PRE: begin ok = (bst[bank] == BANK_OPEN) && (now >= b_pre[bank]); bad_code = ERR_PRE; end
            OP_RD:  begin ok = row_hit && (now >= b_rd[bank]); bad_code = ERR_RD;  end
            OP_RDA: begin ok = row_hit && (now >= b_rd[bank]); bad_code = ERR_RDA; end
            OP_WR:  begin ok = row_hit && (now >= b_wr[bank]); bad_code = ERR_WR;  end
            OP_WRA: begin ok = row_hit && (now >= b_wr[bank]); bad_code = ERR_WRA; end
            OP_REF: begin ok = all_idle; bad_code = ERR_REF; end
            OP_RSV: begin ok = 1'b0;     bad_code = ERR_OP;  end
        endcase
        apply = 1'b0;
        pd_go = 1'b0;
        pu_go = 1'b0;
        bad   = 1'b0;
        if (cmd_valid) begin
            apply = ok;
            bad   = !ok;
        end else if (pd_req) begin
            pd_go    = all_idle && (rank_st == RANK_RUN);
            bad      = !pd_go;
            bad_code = ERR_PDN;
        end else if (pu_req) begin
            pu_go    = (rank_st == RANK_DOWN) && pu_time_ok;
            bad      = !pu_go;
            bad_code = ERR_PUP;
        end else begin
            bad_code = ERR_NONE;
        end
    end

endmodule

// File: rtl/rank_cmd_guard.sv
module rank_cmd_guard
    import rank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int ROW_W     = 8,
    parameter int CNT_W     = 32,
    parameter int T_RC      = 10,
    parameter int T_RCD     = 4,
    parameter int T_AL      = 1,
    parameter int T_RAS     = 7,
    parameter int T_RRD     = 2,
    parameter int T_CCD     = 2,
    parameter int BL        = 8,
    parameter int T_RTP     = 3,
    parameter int T_WTP     = 6,
    parameter int T_RTW     = 5,
    parameter int T_WTR     = 7,
    parameter int T_RDA     = 8,
    parameter int T_WRA     = 11,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 12,
    parameter int T_CKE     = 3,
    parameter int T_XP      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [ROW_W-1:0]     cmd_row,
    input  logic                 pd_req,
    input  logic                 pu_req,
    output logic                 viol_flag,
    output logic [3:0]           viol_code,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 rank_asleep
);

    localparam int CAS_GAP = T_RCD - T_AL;
    localparam int BURST_GAP = (T_CCD > BL / 2) ? T_CCD : BL / 2;

    op_e                            op;
    logic [CNT_W-1:0]               now;
    logic [NUM_BANKS-1:0][1:0]      bst;
    logic [NUM_BANKS-1:0][ROW_W-1:0] orow;
    logic [NUM_BANKS-1:0][CNT_W-1:0] b_act, b_rd, b_wr, b_pre, b_pu;
    logic                           apply, pd_go, pu_go, bad;
    err_e                           bad_code;
    rank_st_e                       rk_q, rk_d;
    viol_st_e                       vs_q, vs_d;
    err_e                           code_q;

    assign op = op_e'(cmd_op);

    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_st_e st_g;
        rank_bank_timer #(
            .CNT_W(CNT_W), .ROW_W(ROW_W), .T_RC(T_RC), .T_CAS(CAS_GAP),
            .T_RAS(T_RAS), .T_RRD(T_RRD), .T_RW(BURST_GAP), .T_RTP(T_RTP),
            .T_WTP(T_WTP), .T_RTW(T_RTW), .T_WTR(T_WTR), .T_RDA(T_RDA),
            .T_WRA(T_WRA), .T_RP(T_RP), .T_RFC(T_RFC), .T_CKE(T_CKE), .T_XP(T_XP)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .now      (now),
            .apply    (apply),
            .op       (op),
            .own      (cmd_bank == BANK_W'(g)),
            .row      (cmd_row),
            .pd_go    (pd_go),
            .pu_go    (pu_go),
            .st       (st_g),
            .open_row (orow[g]),
            .nxt_act  (b_act[g]),
            .nxt_rd   (b_rd[g]),
            .nxt_wr   (b_wr[g]),
            .nxt_pre  (b_pre[g]),
            .nxt_pu   (b_pu[g])
        );
        assign bst[g]       = st_g;
        assign bank_open[g] = (st_g == BANK_OPEN);
    end

    rank_rule_check #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
    ) u_rules (
        .cmd_valid (cmd_valid),
        .op        (op),
        .bank      (cmd_bank),
        .row       (cmd_row),
        .pd_req    (pd_req),
        .pu_req    (pu_req),
        .rank_st   (rk_q),
        .now       (now),
        .bst       (bst),
        .orow      (orow),
        .b_act     (b_act),
        .b_rd      (b_rd),
        .b_wr      (b_wr),
        .b_pre     (b_pre),
        .b_pu      (b_pu),
        .apply     (apply),
        .pd_go     (pd_go),
        .pu_go     (pu_go),
        .bad       (bad),
        .bad_code  (bad_code)
    );

    // rank power machine: GO_SLEEP and WAKE transitions
    always_comb begin
        rk_d = rk_q;
        unique case (rk_q)
            RANK_RUN:  if (pd_go) rk_d = RANK_DOWN;
            RANK_DOWN: if (pu_go) rk_d = RANK_RUN;
        endcase
    end

    // violation machine: single TRIP transition
    always_comb begin
        vs_d = vs_q;
        unique case (vs_q)
            VIOL_CLEAN:   if (bad) vs_d = VIOL_TRIPPED;
            VIOL_TRIPPED: vs_d = VIOL_TRIPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rk_q   <= RANK_RUN;
            vs_q   <= VIOL_CLEAN;
            code_q <= ERR_NONE;
        end else begin
            rk_q <= rk_d;
            vs_q <= vs_d;
            if (vs_q == VIOL_CLEAN && bad) code_q <= bad_code;
        end
    end

    always_comb begin
        viol_flag   = (vs_q == VIOL_TRIPPED);
        viol_code   = code_q;
        rank_asleep = (rk_q == RANK_DOWN);
    end

    // R11
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> viol_flag);

    // R11
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> $stable(viol_code));

    // R11
    code_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |-> (viol_code != 4'd0));

    // R10
    sleep_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rank_asleep |-> (bank_open == '0));

    // R13
    cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !viol_flag && !rank_asleep) |=> !rank_asleep);

endmodule

// File: tb/rank_cmd_guard_bench.sv
`timescale 1ns/100ps
module rank_cmd_guard_bench;

    localparam int NB = 4;

    localparam logic [2:0] ACT = 3'd0, PRE = 3'd1, RD = 3'd2, RDA = 3'd3,
                           WR = 3'd4, WRA = 3'd5, REF = 3'd6, RSV = 3'd7;

    typedef struct {
        logic       flag;
        logic [3:0] code;
        logic [3:0] mask;
        logic       sleep;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic [7:0] cmd_row = 8'd0;
    logic       pd_req = 1'b0;
    logic       pu_req = 1'b0;
    logic       viol_flag;
    logic [3:0] viol_code;
    logic [NB-1:0] bank_open;
    logic       rank_asleep;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    exp_t q[$];

    rank_cmd_guard u_rank_cmd_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .pd_req(pd_req), .pu_req(pu_req),
        .viol_flag(viol_flag), .viol_code(viol_code), .bank_open(bank_open),
        .rank_asleep(rank_asleep)
    );

    always #2.5 clk = ~clk;

    // monitor: compares one expected item per clock, 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (viol_flag !== e.flag || viol_code !== e.code ||
                    bank_open !== e.mask || rank_asleep !== e.sleep) begin
                    fails++;
                    $display("FAIL %s: got flag=%0d code=%0d open=%b asleep=%0d, expected flag=%0d code=%0d open=%b asleep=%0d",
                             e.tag, viol_flag, viol_code, bank_open, rank_asleep,
                             e.flag, e.code, e.mask, e.sleep);
                end
            end
        end
    end

    task automatic drive(input logic cv, input logic [2:0] op, input logic [1:0] b,
                         input logic [7:0] r, input logic pd, input logic pu,
                         input logic ef, input logic [3:0] ec, input logic [3:0] em,
                         input logic es, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_bank = b; cmd_row = r;
        pd_req = pd; pu_req = pu;
        e.flag = ef; e.code = ec; e.mask = em; e.sleep = es; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [1:0] b, input logic [7:0] r,
                       input logic ef, input logic [3:0] ec, input logic [3:0] em,
                       input logic es, input string tag);
        drive(1'b1, op, b, r, 1'b0, 1'b0, ef, ec, em, es, tag);
    endtask

    task automatic pwr(input logic pd, input logic pu, input logic ef, input logic [3:0] ec,
                       input logic [3:0] em, input logic es, input string tag);
        drive(1'b0, 3'd0, 2'd0, 8'd0, pd, pu, ef, ec, em, es, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0; pd_req = 1'b0; pu_req = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmd_valid = 1'b0; pd_req = 1'b0; pu_req = 1'b0;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        pwr(0, 0, 0, 0, 4'b0000, 0, "R1");
        idle(1);

        // R2 read too early, then R11 sticky code with a different violation
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        idle(1);
        cmd(RD, 0, 5, 1, 3, 4'b0001, 0, "R2");
        idle(1);
        cmd(RSV, 0, 0, 1, 3, 4'b0001, 0, "R11");
        idle(3);
        pwr(0, 0, 1, 3, 4'b0001, 0, "R11");
        idle(1);

        // R2 legal read, then row mismatch
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        idle(2);
        cmd(RD, 0, 5, 0, 0, 4'b0001, 0, "R2");
        idle(3);
        cmd(RD, 0, 9, 1, 3, 4'b0001, 0, "R2");
        idle(1);

        // R2 write too early
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        cmd(WR, 0, 5, 1, 5, 4'b0001, 0, "R2");
        idle(1);

        // R4 activate spacing across banks
        do_reset();
        cmd(ACT, 0, 1, 0, 0, 4'b0001, 0, "R3");
        cmd(ACT, 1, 1, 1, 1, 4'b0001, 0, "R4");
        idle(1);
        do_reset();
        cmd(ACT, 0, 1, 0, 0, 4'b0001, 0, "R3");
        idle(1);
        cmd(ACT, 1, 1, 0, 0, 4'b0011, 0, "R4");
        cmd(PRE, 0, 0, 1, 2, 4'b0011, 0, "R11");
        idle(1);

        // R8 precharge at row-open time, R3 reopen at tRC
        do_reset();
        cmd(ACT, 0, 3, 0, 0, 4'b0001, 0, "R3");
        idle(6);
        cmd(PRE, 0, 0, 0, 0, 4'b0000, 0, "R8");
        idle(2);
        cmd(ACT, 0, 3, 0, 0, 4'b0001, 0, "R3");
        idle(1);
        // R3 reopen one cycle before tRC
        do_reset();
        cmd(ACT, 0, 3, 0, 0, 4'b0001, 0, "R3");
        idle(6);
        cmd(PRE, 0, 0, 0, 0, 4'b0000, 0, "R8");
        idle(1);
        cmd(ACT, 0, 3, 1, 1, 4'b0000, 0, "R3");
        idle(1);
        // R8 reopen blocked by tRP
        do_reset();
        cmd(ACT, 0, 3, 0, 0, 4'b0001, 0, "R3");
        idle(8);
        cmd(PRE, 0, 0, 0, 0, 4'b0000, 0, "R8");
        cmd(ACT, 0, 3, 1, 1, 4'b0000, 0, "R8");
        idle(1);

        // R6 write-to-read
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        idle(2);
        cmd(WR, 0, 5, 0, 0, 4'b0001, 0, "R6");
        idle(5);
        cmd(RD, 0, 5, 1, 3, 4'b0001, 0, "R6");
        idle(1);
        // R6 read at bound, R5 precharge blocked by read-to-precharge
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        idle(2);
        cmd(WR, 0, 5, 0, 0, 4'b0001, 0, "R6");
        idle(6);
        cmd(RD, 0, 5, 0, 0, 4'b0001, 0, "R6");
        idle(1);
        cmd(PRE, 0, 0, 1, 2, 4'b0001, 0, "R5");
        idle(1);
        // R5 read-to-write
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        idle(2);
        cmd(RD, 0, 5, 0, 0, 4'b0001, 0, "R5");
        idle(3);
        cmd(WR, 0, 5, 1, 5, 4'b0001, 0, "R5");
        idle(1);
        // R5 read gap shared across banks
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        idle(1);
        cmd(ACT, 1, 6, 0, 0, 4'b0011, 0, "R4");
        cmd(RD, 0, 5, 0, 0, 4'b0011, 0, "R5");
        idle(1);
        cmd(RD, 1, 6, 1, 3, 4'b0011, 0, "R5");
        idle(1);

        // R7 auto-precharge read
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        idle(2);
        cmd(RDA, 0, 5, 0, 0, 4'b0000, 0, "R7");
        idle(6);
        cmd(ACT, 0, 5, 1, 1, 4'b0000, 0, "R7");
        idle(1);
        // R7 auto-precharge write
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        idle(2);
        cmd(WRA, 0, 5, 0, 0, 4'b0000, 0, "R7");
        idle(10);
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R7");
        idle(1);

        // R9 refresh
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        cmd(REF, 0, 0, 1, 7, 4'b0001, 0, "R9");
        idle(1);
        do_reset();
        cmd(REF, 0, 0, 0, 0, 4'b0000, 0, "R9");
        idle(10);
        cmd(ACT, 0, 5, 1, 1, 4'b0000, 0, "R9");
        idle(1);
        do_reset();
        cmd(REF, 0, 0, 0, 0, 4'b0000, 0, "R9");
        idle(11);
        cmd(ACT, 2, 5, 0, 0, 4'b0100, 0, "R9");
        idle(1);

        // R10 power-down and power-up
        do_reset();
        pwr(1, 0, 0, 0, 4'b0000, 1, "R10");
        cmd(ACT, 0, 5, 1, 1, 4'b0000, 1, "R10");
        idle(1);
        do_reset();
        pwr(1, 0, 0, 0, 4'b0000, 1, "R10");
        pwr(0, 1, 1, 9, 4'b0000, 1, "R10");
        idle(1);
        do_reset();
        pwr(1, 0, 0, 0, 4'b0000, 1, "R10");
        idle(2);
        pwr(0, 1, 0, 0, 4'b0000, 0, "R10");
        cmd(ACT, 0, 5, 1, 1, 4'b0000, 0, "R10");
        idle(1);
        do_reset();
        pwr(1, 0, 0, 0, 4'b0000, 1, "R10");
        idle(2);
        pwr(0, 1, 0, 0, 4'b0000, 0, "R10");
        idle(1);
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R10");
        idle(1);
        do_reset();
        cmd(ACT, 0, 5, 0, 0, 4'b0001, 0, "R3");
        idle(1);
        pwr(1, 0, 1, 8, 4'b0001, 0, "R10");
        idle(1);
        do_reset();
        pwr(0, 1, 1, 9, 4'b0000, 0, "R10");
        idle(1);

        // R12 reserved opcode
        do_reset();
        cmd(RSV, 0, 0, 1, 10, 4'b0000, 0, "R12");
        idle(1);

        // R13 priority between simultaneous requests
        do_reset();
        drive(1'b1, ACT, 0, 5, 1'b1, 1'b0, 0, 0, 4'b0001, 0, "R13");
        idle(1);
        pwr(1, 1, 1, 8, 4'b0001, 0, "R13");
        idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule